// File: doc/BRIEF.md
# Dithered Output Word-Length Reducer

This block sits at the end of a 32-bit signed stereo sample path and shortens each sample to 16, 20, 24 or 32 bits. On every accepted sample it adds triangular-PDF dither to each channel. The dither amplitude tracks the chosen length. It then saturates the sum and clears every bit below the kept length. The result appears in a register one cycle later, together with a valid strobe.

Each channel draws its dither from its own pair of 32-bit maximal-length LFSRs. This keeps the noise on the left channel statistically independent of the noise on the right channel. The length select is sampled together with the sample strobe. It therefore only affects the sample that arrives with it.

Top module: `ditherTrim`

## Requirements
- R1: After reset, `outValid` is 0 and both `outLeft` and `outRight` are 0.
- R2: `outValid` is high for exactly one cycle, in the cycle after each cycle in which `inValid` is high. It is never high otherwise.
- R3: `lenSel` selects the kept length: 2'b00 keeps 16 bits, 2'b01 keeps 20, 2'b10 keeps 24 and 2'b11 keeps 32. Let s = 32 minus the kept length. The low s bits of every output word are 0.
- R4: Each channel's dither is d = (A & M) - (B & M), where M = 2^s - 1 and A, B are that channel's two LFSR states at the strobe. The output is then saturate(x + d), with its low s bits cleared.
- R5: Every LFSR is a 32-bit Galois register that shifts right. When the bit shifted out is 1, the new value is XORed with 32'h80200003. Each LFSR steps exactly once per accepted strobe. The seeds are: left A 32'h12345678, left B 32'h9ABCDEF1, right A 32'h0F1E2D3C and right B 32'h5A5AA5A6.
- R6: The sum x + d saturates to 32'h7FFFFFFF or 32'h80000000 instead of wrapping.
- R7: With 32 bits kept, the output equals the input sample exactly.
- R8: Between strobes, `lenSel` and the data inputs have no effect: the outputs hold their last values.
- R9: The left and right channels use separate noise sources. With equal inputs on both channels, the two outputs differ on some samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Sample strobe |
| inLeft | input | 32 | Left sample, signed |
| inRight | input | 32 | Right sample, signed |
| lenSel | input | 2 | Kept-length select |
| outValid | output | 1 | Output strobe |
| outLeft | output | 32 | Reduced left word |
| outRight | output | 32 | Reduced right word |

## Verification
Saturation and truncation can act on the same sample. A full-scale positive or negative input combined with dither that pushes past the rail must clamp first and then be masked. The bench drives both rails and values one LSB away from them at every length. It compares each output with an arithmetic model that computes the 64-bit sum, the clamp and the mask from the bench's own LFSR sequence. A length change during idle cycles is also sent right before a strobe, to confirm that the new length applies only to that strobe.

// File: rtl/trimPkg.sv
package trimPkg;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] LFSR_TAPS = 32'h80200003;
  // channel-major: [0] left A, [1] left B, [2] right A, [3] right B
  localparam logic [3:0][DATA_W-1:0] LFSR_SEEDS =
    {32'h5A5AA5A6, 32'h0F1E2D3C, 32'h9ABCDEF1, 32'h12345678};

  typedef struct packed {
    logic              load;
    logic [DATA_W-1:0] lowMask;
  } trimCtrlT;
endpackage

// File: rtl/trimControl.sv
module trimControl
  import trimPkg::*;
(
  input  logic       inValid,
  input  logic [1:0] lenSel,
  output trimCtrlT   ctrl
);
  localparam int NumLens = 4;
  localparam int KeepLens [NumLens] = '{16, 20, 24, 32};

  logic [NumLens-1:0][DATA_W-1:0] maskTable;

  for (genvar g = 0; g < NumLens; g++) begin : gMask
    localparam int Drop = DATA_W - KeepLens[g];
    if (Drop == 0) begin : gNone
      assign maskTable[g] = '0;
    end else begin : gSome
      assign maskTable[g] = {DATA_W{1'b1}} >> (DATA_W - Drop);
    end
  end

  always_comb begin
    ctrl.load    = inValid;
    ctrl.lowMask = maskTable[lenSel];
  end
endmodule

// File: rtl/ditherGen.sv
module ditherGen
  import trimPkg::*;
#(
  parameter logic [DATA_W-1:0] SeedA = 32'h1,
  parameter logic [DATA_W-1:0] SeedB = 32'h2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     advance,
  input  logic [DATA_W-1:0]        lowMask,
  output logic signed [DATA_W:0]   dither
);
  logic [1:0][DATA_W-1:0] lfsrState;

  for (genvar g = 0; g < 2; g++) begin : gLfsr
    localparam logic [DATA_W-1:0] Seed = (g == 0) ? SeedA : SeedB;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lfsrState[g] <= Seed;
      end else if (advance) begin
        lfsrState[g] <= lfsrState[g][0] ? ((lfsrState[g] >> 1) ^ LFSR_TAPS)
                                        : (lfsrState[g] >> 1);
      end
    end
    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rstN)
      lfsrState[g] != '0); // R5
  end

  logic [DATA_W-1:0] uniA, uniB;
  assign uniA   = lfsrState[0] & lowMask;
  assign uniB   = lfsrState[1] & lowMask;
  assign dither = $signed({1'b0, uniA}) - $signed({1'b0, uniB});

  AST_DITHER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (dither[DATA_W] ? ((-dither) <= $signed({1'b0, lowMask}))
                    : (dither <= $signed({1'b0, lowMask})))); // R4
endmodule

// File: rtl/trimDatapath.sv
module trimDatapath
  import trimPkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  trimCtrlT               ctrl,
  input  logic [DATA_W-1:0]      inLeft,
  input  logic [DATA_W-1:0]      inRight,
  input  logic signed [DATA_W:0] ditherLeft,
  input  logic signed [DATA_W:0] ditherRight,
  output logic                   outValid,
  output logic [DATA_W-1:0]      outLeft,
  output logic [DATA_W-1:0]      outRight
);
  localparam logic [DATA_W-1:0] PosMax = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NegMax = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic logic [DATA_W-1:0] satTrim(
    input logic [DATA_W-1:0] x, input logic signed [DATA_W:0] d,
    input logic [DATA_W-1:0] m);
    logic signed [DATA_W:0] sum;
    logic [DATA_W-1:0] clamped;
    sum = $signed({x[DATA_W-1], x}) + d;
    if (sum[DATA_W] != sum[DATA_W-1]) clamped = sum[DATA_W] ? NegMax : PosMax;
    else                              clamped = sum[DATA_W-1:0];
    return clamped & ~m;
  endfunction

  logic [DATA_W-1:0] nextLeft, nextRight, lowMaskQ;
  assign nextLeft  = satTrim(inLeft,  ditherLeft,  ctrl.lowMask);
  assign nextRight = satTrim(inRight, ditherRight, ctrl.lowMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outLeft  <= '0;
      outRight <= '0;
      lowMaskQ <= '0;
    end else begin
      outValid <= ctrl.load;
      if (ctrl.load) begin
        outLeft  <= nextLeft;
        outRight <= nextRight;
        lowMaskQ <= ctrl.lowMask;
      end
    end
  end

  AST_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> outValid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> !outValid); // R2
  AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (((outLeft | outRight) & lowMaskQ) == '0)); // R3
  AST_PASS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.lowMask == '0) |=> (outLeft == $past(inLeft) && outRight == $past(inRight))); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && !inLeft[DATA_W-1] && !ditherLeft[DATA_W]) |=> !outLeft[DATA_W-1]); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && inLeft[DATA_W-1] && ditherLeft[DATA_W]) |=> outLeft[DATA_W-1]); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> ($stable(outLeft) && $stable(outRight))); // R8
endmodule

// File: rtl/ditherTrim.sv
module ditherTrim
  import trimPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inLeft,
  input  logic [DATA_W-1:0] inRight,
  input  logic [1:0]        lenSel,
  output logic              outValid,
  output logic [DATA_W-1:0] outLeft,
  output logic [DATA_W-1:0] outRight
);
  trimCtrlT ctrl;
  logic signed [1:0][DATA_W:0] chDither;

  trimControl u_ctrl (.inValid(inValid), .lenSel(lenSel), .ctrl(ctrl));

  for (genvar ch = 0; ch < 2; ch++) begin : gChan
    ditherGen #(.SeedA(LFSR_SEEDS[2*ch]), .SeedB(LFSR_SEEDS[2*ch+1])) u_dither (
      .clk(clk), .rstN(rstN), .advance(ctrl.load),
      .lowMask(ctrl.lowMask), .dither(chDither[ch]));
  end

  trimDatapath u_path (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .inLeft(inLeft), .inRight(inRight),
    .ditherLeft(chDither[0]), .ditherRight(chDither[1]),
    .outValid(outValid), .outLeft(outLeft), .outRight(outRight));
endmodule

// File: tb/ditherTrim_tb.sv
module ditherTrim_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] inLeft = '0, inRight = '0;
  logic [1:0] lenSel = '0;
  logic outValid;
  logic [31:0] outLeft, outRight;

  int testsRun = 0, testsFailed = 0;
  logic [31:0] mLA, mLB, mRA, mRB;
  logic [31:0] expL, expR;

  always #4 clk = ~clk;

  ditherTrim u_dut (.clk(clk), .rstN(rstN), .inValid(inValid), .inLeft(inLeft),
    .inRight(inRight), .lenSel(lenSel), .outValid(outValid),
    .outLeft(outLeft), .outRight(outRight));

  function automatic logic [31:0] stepLfsr(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ 32'h80200003) : (s >> 1);
  endfunction

  function automatic int dropFor(input logic [1:0] sel);
    case (sel)
      2'd0: return 16;
      2'd1: return 12;
      2'd2: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] model(input logic [31:0] x, input logic [31:0] a,
                                        input logic [31:0] b, input int drop);
    longint m, d, sum;
    m = (64'sd1 <<< drop) - 1;
    d = longint'({32'd0, a} & m) - longint'({32'd0, b} & m);
    sum = longint'($signed(x)) + d;
    if (sum > 64'sd2147483647) sum = 64'sd2147483647;
    if (sum < -64'sd2147483648) sum = -64'sd2147483648;
    return sum[31:0] & ~m[31:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one strobe, update model, check at next negedge
  task automatic sendSample(input logic [31:0] l, input logic [31:0] r, input logic [1:0] sel);
    @(negedge clk);
    inValid = 1'b1; inLeft = l; inRight = r; lenSel = sel;
    expL = model(l, mLA, mLB, dropFor(sel));
    expR = model(r, mRA, mRB, dropFor(sel));
    mLA = stepLfsr(mLA); mLB = stepLfsr(mLB);
    mRA = stepLfsr(mRA); mRB = stepLfsr(mRB);
    @(negedge clk);
    inValid = 1'b0;
    check("R2 valid", {31'd0, outValid}, 32'd1);
    check("R4 left", outLeft, expL);
    check("R4 right", outRight, expR);
  endtask

  initial begin
    #1000000;
    testsFailed++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [31:0] pat;
    int diffCount;
    mLA = 32'h12345678; mLB = 32'h9ABCDEF1; mRA = 32'h0F1E2D3C; mRB = 32'h5A5AA5A6;
    repeat (3) @(negedge clk);
    check("R1 valid", {31'd0, outValid}, 32'd0);
    check("R1 left", outLeft, 32'd0);
    check("R1 right", outRight, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 idle", {31'd0, outValid}, 32'd0);

    // R3 R4 R5 R6: sweep all lengths with rails, near-rails and mixed data
    for (int s = 0; s < 4; s++) begin
      sendSample(32'h7FFFFFFF, 32'h80000000, 2'(s));
      sendSample(32'h80000000, 32'h7FFFFFFF, 2'(s));
      sendSample(32'h7FFFFFFE, 32'h80000001, 2'(s));
      sendSample(32'h7FFF0000, 32'h8000FFFF, 2'(s));
      for (int k = 0; k < 40; k++) begin
        pat = 32'(k) * 32'h9E3779B1 ^ 32'(s) * 32'h01234567;
        sendSample(pat, ~pat + 32'(k), 2'(s));
        check("R3 low bits", outLeft & ((32'd1 << dropFor(2'(s))) - 1), 32'd0);
      end
    end

    // R7: 32-bit passthrough, exact copy
    for (int k = 0; k < 8; k++) begin
      pat = 32'hA5A5_0000 + 32'(k * 7919);
      sendSample(pat, 32'h7FFFFFFF - 32'(k), 2'd3);
      check("R7 left", outLeft, pat);
      check("R7 right", outRight, 32'h7FFFFFFF - 32'(k));
    end

    // R6: explicit rail checks at 16 bits
    sendSample(32'h7FFFFFFF, 32'h80000000, 2'd0);
    check("R6 pos rail sign", {31'd0, outLeft[31]}, 32'd0);
    check("R6 neg rail sign", {31'd0, outRight[31]}, 32'd1);

    // R8: idle changes on lenSel and data are ignored
    sendSample(32'h12345678, 32'h87654321, 2'd2);
    @(negedge clk);
    lenSel = 2'd0; inLeft = 32'hFFFFFFFF; inRight = 32'h0;
    repeat (3) @(negedge clk);
    check("R8 hold left", outLeft, expL);
    check("R8 hold right", outRight, expR);
    check("R8 no valid", {31'd0, outValid}, 32'd0);
    sendSample(32'h12345678, 32'h12345678, 2'd1);

    // R9: identical channel inputs give differing outputs somewhere
    diffCount = 0;
    for (int k = 0; k < 16; k++) begin
      sendSample(32'h00001234, 32'h00001234, 2'd0);
      if (outLeft != outRight) diffCount++;
    end
    testsRun++;
    if (diffCount == 0) begin
      testsFailed++;
      $display("FAIL R9 actual=%0d expected>0", diffCount);
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule